// File: doc/BRIEF.md
# Transmit Buffer Flag Register

This block holds the status flags of a message controller that owns three transmit buffers. Each buffer has two flags. The empty flag shows that the buffer is free to take a new message. The abort-acknowledge flag shows whether the buffer's last message was withdrawn at CPU request or was actually sent. Hardware events from the transmit engine set the flags. The CPU clears an empty flag by writing a one to it, and it queues a message with a per-buffer load strobe.

A separate three-bit enable register, written through the same simple bus, selects which empty flags may raise the transmit interrupt request. The read port always returns the flag register. Both registers return to their reset values on an asynchronous hard reset or on a synchronous soft reset.

Top module: `txbuf_flag_reg`

## Requirements
- R1: The read value has this layout: bit 7 and bit 3 read 0. Bits 6, 5 and 4 hold the abort-acknowledge flags of buffers 2, 1 and 0. Bits 2, 1 and 0 hold the empty flags of buffers 2, 1 and 0.
- R2: A hard reset (`rst_n` low, asynchronous) or a soft reset (`soft_rst` high at a clock edge) sets every empty flag to 1, every abort-acknowledge flag to 0 and every enable bit to 0. A soft reset takes precedence over every other input in that cycle.
- R3: A bus write with `wr_sel` = 0 addresses the flag register. A 1 in bit i (i = 0..2) clears buffer i's empty flag, and a 0 leaves it unchanged.
- R4: A flag-register write has no effect through bits 7 to 3. The reserved bits stay 0, and the abort-acknowledge flags keep their value.
- R5: A pulse on `load[i]` clears buffer i's empty flag at the next clock edge.
- R6: A pulse on `tx_done[i]` sets buffer i's empty flag and leaves its abort-acknowledge flag at 0.
- R7: A pulse on `abort_done[i]` sets buffer i's empty flag and its abort-acknowledge flag.
- R8: Whenever buffer i's empty flag goes from 1 to 0, through a load or through a CPU clear, its abort-acknowledge flag becomes 0 in the same cycle.
- R9: When `tx_done[i]` and `abort_done[i]` arrive in the same cycle, the empty flag is set and the abort-acknowledge flag is 0.
- R10: When a hardware set (`tx_done` or `abort_done`) of a buffer coincides with a CPU clear or a load of the same buffer, the flag ends up set.
- R11: A bus write with `wr_sel` = 1 loads bits 2..0 into the enable register. `irq` is the OR over the buffers of the empty flag ANDed with the enable bit. It stays high until the flag is cleared or the enable is removed. A write to the enable register does not change the read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| wr_en | input | 1 | Bus write strobe |
| wr_sel | input | 1 | Write target: 0 = flag register, 1 = enable register |
| wr_data | input | 8 | Bus write data |
| load | input | 3 | Per-buffer strobe that queues a message |
| tx_done | input | 3 | Per-buffer pulse: message sent |
| abort_done | input | 3 | Per-buffer pulse: message aborted |
| rd_data | output | 8 | Flag register read value |
| irq | output | 1 | Transmit interrupt request |

## Verification
The assertions assume single-cycle event pulses that are sampled at each clock edge. They assume that a soft reset overrides anything else in its cycle, so every next-cycle property excludes cycles in which `soft_rst` is high. The bench changes every input on the falling edge and holds each pulse for exactly one cycle. It uses overlapping events only in the deliberate race cases, and it never combines a soft reset with a hardware event in the same cycle.

// File: rtl/txbuf_flag_reg.sv
module txbuf_flag_reg #(
  parameter int NBUF = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [7:0]      wr_data,
  input  logic [NBUF-1:0] load,
  input  logic [NBUF-1:0] tx_done,
  input  logic [NBUF-1:0] abort_done,
  output logic [7:0]      rd_data,
  output logic            irq
);

  logic [NBUF-1:0] empty_q, ack_q, ien_q;
  logic [NBUF-1:0] hw_set, clr_req;

  assign hw_set  = tx_done | abort_done;
  assign clr_req = load | ({NBUF{wr_en & ~wr_sel}} & wr_data[NBUF-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= '1;
      ack_q   <= '0;
      ien_q   <= '0;
    end else if (soft_rst) begin
      empty_q <= '1;
      ack_q   <= '0;
      ien_q   <= '0;
    end else begin
      for (int i = 0; i < NBUF; i++) begin
        if (hw_set[i]) begin
          empty_q[i] <= 1'b1;
          ack_q[i]   <= abort_done[i] & ~tx_done[i];
        end else if (clr_req[i]) begin
          empty_q[i] <= 1'b0;
          ack_q[i]   <= 1'b0;
        end
      end
      if (wr_en && wr_sel) ien_q <= wr_data[NBUF-1:0];
    end
  end

  assign rd_data = {1'b0, ack_q, 1'b0, empty_q};
  assign irq     = |(empty_q & ien_q);

  for (genvar g = 0; g < NBUF; g++) begin : g_chk
    AST_ACK_DROPS_WITH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_data[g]) |-> !rd_data[4+g]); // R8
    AST_ACK_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[4+g] |-> rd_data[g]); // R7
    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (!soft_rst && (tx_done[g] || abort_done[g])) |=> rd_data[g]); // R10
    AST_TX_BEATS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (!soft_rst && tx_done[g]) |=> !rd_data[4+g]); // R9
    AST_ABORT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (!soft_rst && abort_done[g] && !tx_done[g]) |=> rd_data[4+g]); // R7
    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (!soft_rst && load[g] && !tx_done[g] && !abort_done[g]) |=> !rd_data[g]); // R5
  end

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (rd_data == 8'h07 && !irq)); // R2
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rd_data[2:0] != 3'b000)); // R11

endmodule

// File: tb/txbuf_flag_reg_tb_top.sv
module txbuf_flag_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] load = '0, tx_done = '0, abort_done = '0;
  logic [7:0] rd_data;
  logic       irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  txbuf_flag_reg dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .load(load), .tx_done(tx_done), .abort_done(abort_done),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle of stimulus, then return on the next falling edge
  task automatic step(input logic [2:0] ld, input logic [2:0] tx, input logic [2:0] ab,
                      input logic we, input logic sel, input logic [7:0] d);
    load = ld; tx_done = tx; abort_done = ab; wr_en = we; wr_sel = sel; wr_data = d;
    @(negedge clk);
    load = '0; tx_done = '0; abort_done = '0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00;
  endtask

  task automatic hard_reset();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    @(negedge clk);
    chk("R2 hard reset value", rd_data, 8'h07);
    chk("R2 irq in reset", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reserved bits zero", rd_data & 8'h88, 8'h00);
  endtask

  task automatic t_send();
    hard_reset();
    step(3'b001, 0, 0, 0, 0, 0);
    chk("R5 load clears empty0", rd_data, 8'h06);
    step(0, 3'b001, 0, 0, 0, 0);
    chk("R6 tx_done sets empty, no ack", rd_data, 8'h07);
  endtask

  task automatic t_abort();
    hard_reset();
    step(3'b010, 0, 0, 0, 0, 0);
    chk("R5 load clears empty1", rd_data, 8'h05);
    step(0, 0, 3'b010, 0, 0, 0);
    chk("R7 abort sets ack1 bit5", rd_data, 8'h27);
    step(3'b010, 0, 0, 0, 0, 0);
    chk("R8 ack cleared by load", rd_data, 8'h05);
    step(0, 0, 3'b010, 0, 0, 0);
    chk("R7 abort again", rd_data, 8'h27);
    step(0, 0, 0, 1, 0, 8'h02);
    chk("R8 ack cleared by CPU clear", rd_data, 8'h05);
  endtask

  task automatic t_writes();
    hard_reset();
    step(3'b100, 0, 0, 0, 0, 0);
    step(0, 0, 3'b100, 0, 0, 0);
    chk("R1 ack2 at bit6", rd_data, 8'h47);
    step(0, 0, 0, 1, 0, 8'h00);
    chk("R3 write zero no effect", rd_data, 8'h47);
    step(0, 0, 0, 1, 0, 8'hF8);
    chk("R4 upper bits ignored", rd_data, 8'h47);
    step(0, 0, 0, 1, 0, 8'h01);
    chk("R3 write one clears empty0", rd_data, 8'h46);
  endtask

  task automatic t_race();
    hard_reset();
    step(3'b100, 0, 0, 0, 0, 0);
    step(0, 3'b100, 3'b100, 0, 0, 0);
    chk("R9 tx beats abort", rd_data, 8'h07);
    step(3'b001, 0, 0, 0, 0, 0);
    step(0, 3'b001, 0, 1, 0, 8'h01);
    chk("R10 tx set beats CPU clear", rd_data, 8'h07);
    step(3'b010, 0, 0, 0, 0, 0);
    step(0, 0, 3'b010, 1, 0, 8'h02);
    chk("R10 abort set beats CPU clear", rd_data, 8'h27);
    step(3'b001, 3'b001, 0, 0, 0, 0);
    chk("R10 set beats load", rd_data, 8'h27);
  endtask

  task automatic t_irq();
    hard_reset();
    step(0, 0, 0, 1, 1, 8'h02);
    chk("R11 enable write leaves flags", rd_data, 8'h07);
    chk("R11 irq on enabled empty1", {7'd0, irq}, 8'h01);
    step(0, 0, 0, 1, 0, 8'h02);
    chk("R11 irq drops on clear", {7'd0, irq}, 8'h00);
    step(0, 3'b010, 0, 0, 0, 0);
    chk("R11 irq on send", {7'd0, irq}, 8'h01);
    step(0, 0, 0, 1, 1, 8'h00);
    chk("R11 irq drops on disable", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_soft();
    hard_reset();
    step(3'b011, 0, 0, 0, 0, 0);
    step(0, 0, 3'b001, 1, 1, 8'h07);
    chk("R7 ack0 at bit4", rd_data, 8'h15);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk("R2 soft reset value", rd_data, 8'h07);
    chk("R2 soft reset clears enables", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_send();
    t_abort();
    t_writes();
    t_race();
    t_irq();
    t_soft();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule